// File: doc/BRIEF.md
# Dual-Host Control Register Bank

This block holds a bank of 32 eight-bit locations that two independent host controllers reach concurrently. One host talks over a multiplexed parallel bus of the 8051 family. Its eight bidirectional lines first carry an address, which an address-latch strobe captures, and then carry data under active-low read and write strobes that an active-high chip select gates. The other host is an I2C master, and the block answers it as a slave. A written byte selects a register pointer, and that pointer survives the STOP condition, so a later read transaction can fetch from it.

Every location is split in two. A write from either host lands in a control register that is presented to the rest of the chip. A read from either host returns a status byte that the rest of the chip supplies. When both hosts commit a write in the same clock cycle, a small arbiter lets the parallel write through first and applies the serial write one cycle later. An open-drain interrupt request is raised when a status byte at one fixed location shares a set bit with an enable mask held in the control register at another fixed location.

Top module: `dual_host_regs`

## Requirements
- R1: After a synchronous reset, all 32 control registers read 0x00 on `ctrl_o`, with location i at bits [8i+7:8i].
- R2: On the parallel bus, a high `pb_ale` latches `pb_ad_i`. A falling edge of `pb_wr_n` while `pb_cs` is high writes the byte on `pb_ad_i` into the control register at the latched address, and the new value shows on `ctrl_o` four clock cycles after the strobe edge.
- R3: While `pb_cs` is high and `pb_rd_n` is low, `pb_ad_oe` is 1 and `pb_ad_o` carries the status byte of the latched address. At all other times `pb_ad_oe` is 0.
- R4: When `pb_cs` is low, the read and write strobes have no effect: no control register changes and `pb_ad_oe` stays 0.
- R5: The I2C slave address is 7'h1F, so the address byte is 0x3E to write and 0x3F to read. The block acknowledges (pulls SDA low) those address bytes and every byte written after them. It does not acknowledge any other address, and the bytes that follow such an address are neither acknowledged nor written.
- R6: The I2C sequence START, 0x3E, pointer byte, data byte, STOP writes the data byte into the control register selected by the pointer.
- R7: The I2C pointer stays set after STOP. The sequence START, 0x3F then shifts out the status byte at that pointer, MSB first, one bit per SCL low phase.
- R8: A read from either host returns the status input of the addressed location, never the control register written at that location.
- R9: Only the low 5 bits of an address are decoded, on both hosts. For example, an I2C pointer of 0x25 selects location 5, and a parallel address of 0xE2 selects location 2.
- R10: Locations 28 to 31 are reserved. They read 0x00 from both hosts whatever the status input holds, and writes to them leave `ctrl_o` at 0x00.
- R11: When a parallel write and an I2C write commit in the same cycle, the parallel value is applied first and the I2C value one cycle later. At a shared address the I2C value is therefore the one that remains.
- R12: `irq_pull` is 1 (the open-drain line is driven low) exactly when control location 11 and status location 12 have a set bit in common. It follows them with one cycle of delay.
- R13: After reset, `pb_ad_oe`, `i2c_sda_oe` and `irq_pull` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pb_ad_i | input | 8 | Parallel bus address/data, sampled from the pins |
| pb_ad_o | output | 8 | Parallel bus read data toward the pins |
| pb_ad_oe | output | 1 | Parallel bus output enable |
| pb_ale | input | 1 | Address latch enable, active high |
| pb_wr_n | input | 1 | Write strobe, active low |
| pb_rd_n | input | 1 | Read strobe, active low |
| pb_cs | input | 1 | Chip select, active high |
| i2c_scl_i | input | 1 | I2C clock line level |
| i2c_sda_i | input | 1 | I2C data line level |
| i2c_sda_oe | output | 1 | 1 pulls the SDA line low |
| stat_i | input | 256 | Status bytes, location i at bits [8i+7:8i] |
| ctrl_o | output | 256 | Control bytes, location i at bits [8i+7:8i] |
| irq_pull | output | 1 | 1 drives the open-drain interrupt line low |

## Verification
Parallel and serial writes are driven at distinct ordinary locations and then read back through each host. Setting the status bytes to values that differ from everything written shows that reads see the status side and not the control side. Pointer and parallel addresses with high bits set separate full-width decoding from 5-bit decoding, and writes with chip select low separate gated strobes from ungated ones. A foreign I2C slave address tests rejection. A parallel write and a serial write whose strobe edges land on the same clock edge at one address show the commit order cycle by cycle. Flipping the interrupt mask between an overlapping value and a disjoint value shows that the interrupt depends on the AND of the two bytes.

// File: rtl/dhr_pkg.sv
package dhr_pkg;

    localparam int NREG = 32;
    localparam int DW   = 8;
    localparam int AW   = $clog2(NREG);
    localparam int BUSW = NREG * DW;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef enum logic [3:0] {
        SL_IDLE,
        SL_ADDR,
        SL_ADDR_ACK,
        SL_PTR,
        SL_PTR_ACK,
        SL_WDAT,
        SL_WDAT_ACK,
        SL_RDAT,
        SL_SKIP
    } slv_st_e;

    // Status byte for a location; reserved locations read as zero
    function automatic logic [DW-1:0] stat_pick(
        input logic [BUSW-1:0] st,
        input logic [AW-1:0]   a,
        input logic [NREG-1:0] rsv
    );
        logic [DW-1:0] b;
        b = st[DW*a +: DW];
        return rsv[a] ? '0 : b;
    endfunction

endpackage

// File: rtl/dhr_sync.sv
module dhr_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= RST_VAL;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/dhr_pbus_port.sv
module dhr_pbus_port
    import dhr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ad_i,
    input  logic          ale_i,
    input  logic          wr_n_i,
    input  logic          rd_n_i,
    input  logic          cs_i,
    output logic [AW-1:0] addr_o,
    output logic          ad_oe_o,
    output wr_req_t       wreq_o
);
    localparam int SW = DW + 4;
    localparam logic [SW-1:0] IDLE_LVL = {{DW{1'b0}}, 1'b0, 1'b1, 1'b1, 1'b0};

    logic [SW-1:0] raw, synced;
    logic [DW-1:0] ad_s;
    logic          ale_s, wr_s, rd_s, cs_s;
    logic          wr_prev;
    logic [AW-1:0] addr_q;
    logic          wr_fall;

    assign raw = {ad_i, ale_i, wr_n_i, rd_n_i, cs_i};

    dhr_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign {ad_s, ale_s, wr_s, rd_s, cs_s} = synced;
    assign wr_fall = cs_s & ~wr_s & wr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b1;
            addr_q  <= '0;
            wreq_o  <= '0;
        end else begin
            wr_prev <= wr_s;
            if (ale_s) addr_q <= ad_s[AW-1:0];
            wreq_o.v    <= wr_fall;
            wreq_o.addr <= addr_q;
            wreq_o.data <= ad_s;
        end
    end

    assign addr_o  = addr_q;
    assign ad_oe_o = cs_s & ~rd_s;

    // A strobe edge yields exactly one commit pulse
    p_wr_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        wreq_o.v |=> !wreq_o.v);

endmodule

// File: rtl/dhr_i2c_slave.sv
module dhr_i2c_slave
    import dhr_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h1F,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr_o,
    output wr_req_t       wreq_o,
    output logic          sda_oe_o
);
    logic [1:0]    lines;
    logic          scl_s, sda_s, scl_p, sda_p;
    logic          start_c, stop_c, rise_c, fall_c;
    slv_st_e       st;
    logic [3:0]    cnt;
    logic [DW-1:0] shreg, txb;
    logic          rw;

    dhr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines)
    );
    assign {scl_s, sda_s} = lines;

    assign start_c = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
    assign rise_c  = scl_s & ~scl_p;
    assign fall_c  = ~scl_s & scl_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            st       <= SL_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txb      <= '0;
            rw       <= 1'b0;
            ptr_o    <= '0;
            wreq_o   <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            scl_p    <= scl_s;
            sda_p    <= sda_s;
            wreq_o.v <= 1'b0;
            if (start_c) begin
                st       <= SL_ADDR;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_c) begin
                st       <= SL_IDLE;
                sda_oe_o <= 1'b0;
            end else if (rise_c) begin
                if (st == SL_ADDR || st == SL_PTR || st == SL_WDAT) begin
                    shreg <= {shreg[DW-2:0], sda_s};
                    cnt   <= cnt + 4'd1;
                end else if (st == SL_RDAT) begin
                    cnt <= cnt + 4'd1;
                end
            end else if (fall_c) begin
                case (st)
                    SL_ADDR: if (cnt == 4'd8) begin
                        if (shreg[7:1] == SLV_ADDR) begin
                            rw       <= shreg[0];
                            sda_oe_o <= 1'b1;
                            st       <= SL_ADDR_ACK;
                        end else begin
                            st <= SL_SKIP;
                        end
                    end
                    SL_ADDR_ACK: begin
                        cnt <= '0;
                        if (rw) begin
                            txb      <= rd_data;
                            sda_oe_o <= ~rd_data[DW-1];
                            st       <= SL_RDAT;
                        end else begin
                            sda_oe_o <= 1'b0;
                            st       <= SL_PTR;
                        end
                    end
                    SL_PTR: if (cnt == 4'd8) begin
                        ptr_o    <= shreg[AW-1:0];
                        sda_oe_o <= 1'b1;
                        st       <= SL_PTR_ACK;
                    end
                    SL_PTR_ACK: begin
                        cnt      <= '0;
                        sda_oe_o <= 1'b0;
                        st       <= SL_WDAT;
                    end
                    SL_WDAT: if (cnt == 4'd8) begin
                        wreq_o.v    <= 1'b1;
                        wreq_o.addr <= ptr_o;
                        wreq_o.data <= shreg;
                        sda_oe_o    <= 1'b1;
                        st          <= SL_WDAT_ACK;
                    end
                    SL_WDAT_ACK: begin
                        sda_oe_o <= 1'b0;
                        st       <= SL_SKIP;
                    end
                    SL_RDAT: begin
                        if (cnt == 4'd8) begin
                            sda_oe_o <= 1'b0;
                            st       <= SL_SKIP;
                        end else begin
                            sda_oe_o <= ~txb[3'(4'd7 - cnt)];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA is only pulled low while SCL is low
    p_sda_drive_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_s);

    // The pointer survives a STOP condition
    p_ptr_kept_r7: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> $stable(ptr_o));

endmodule

// File: rtl/dhr_ctrl_bank.sv
module dhr_ctrl_bank
    import dhr_pkg::*;
#(
    parameter logic [NREG-1:0] RSV_MASK = 32'hF000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         par_req,
    input  wr_req_t         ser_req,
    output logic [BUSW-1:0] ctrl_o
);
    wr_req_t pend_q, pend_n, commit;

    always_comb begin
        if (par_req.v)     commit = par_req;
        else if (pend_q.v) commit = pend_q;
        else               commit = ser_req;

        if (par_req.v)     pend_n = ser_req.v ? ser_req : pend_q;
        else if (pend_q.v) pend_n = ser_req;
        else               pend_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_n;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (RSV_MASK[g]) begin : g_rsv
            assign ctrl_o[g*DW +: DW] = '0;
        end else begin : g_live
            logic [DW-1:0] r_q;
            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= '0;
                else if (commit.v && commit.addr == AW'(g))
                    r_q <= commit.data;
            end
            assign ctrl_o[g*DW +: DW] = r_q;
        end
    end

    // A deferred serial write is applied on the following cycle
    p_pend_drains_r11: assert property (@(posedge clk) disable iff (rst)
        pend_q.v |=> !pend_q.v);

    // On a collision the serial request is held, unchanged, for one cycle
    p_par_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (par_req.v && ser_req.v) |=> (pend_q.v && pend_q.data == $past(ser_req.data)));

endmodule

// File: rtl/dual_host_regs.sv
module dual_host_regs
    import dhr_pkg::*;
#(
    parameter logic [6:0]      SLV_ADDR    = 7'h1F,
    parameter int              IEN_IDX     = 11,
    parameter int              ISTAT_IDX   = 12,
    parameter logic [NREG-1:0] RSV_MASK    = 32'hF000_0000,
    parameter int              SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   pb_ad_i,
    output logic [DW-1:0]   pb_ad_o,
    output logic            pb_ad_oe,
    input  logic            pb_ale,
    input  logic            pb_wr_n,
    input  logic            pb_rd_n,
    input  logic            pb_cs,
    input  logic            i2c_scl_i,
    input  logic            i2c_sda_i,
    output logic            i2c_sda_oe,
    input  logic [BUSW-1:0] stat_i,
    output logic [BUSW-1:0] ctrl_o,
    output logic            irq_pull
);
    wr_req_t       par_req, ser_req;
    logic [AW-1:0] pb_addr, i2c_ptr;
    logic [DW-1:0] i2c_rd;
    logic [DW-1:0] ien_b, ist_b;

    dhr_pbus_port #(.SYNC_STAGES(SYNC_STAGES)) u_pbus (
        .clk     (clk),
        .rst     (rst),
        .ad_i    (pb_ad_i),
        .ale_i   (pb_ale),
        .wr_n_i  (pb_wr_n),
        .rd_n_i  (pb_rd_n),
        .cs_i    (pb_cs),
        .addr_o  (pb_addr),
        .ad_oe_o (pb_ad_oe),
        .wreq_o  (par_req)
    );

    dhr_i2c_slave #(.SLV_ADDR(SLV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_i2c (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (i2c_scl_i),
        .sda_i    (i2c_sda_i),
        .rd_data  (i2c_rd),
        .ptr_o    (i2c_ptr),
        .wreq_o   (ser_req),
        .sda_oe_o (i2c_sda_oe)
    );

    dhr_ctrl_bank #(.RSV_MASK(RSV_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .par_req (par_req),
        .ser_req (ser_req),
        .ctrl_o  (ctrl_o)
    );

    assign pb_ad_o = stat_pick(stat_i, pb_addr, RSV_MASK);
    assign i2c_rd  = stat_pick(stat_i, i2c_ptr, RSV_MASK);

    assign ien_b = ctrl_o[IEN_IDX*DW +: DW];
    assign ist_b = stat_i[ISTAT_IDX*DW +: DW];

    always_ff @(posedge clk) begin
        if (rst) irq_pull <= 1'b0;
        else     irq_pull <= |(ien_b & ist_b);
    end

    // An all-zero enable mask keeps the interrupt line released
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(ien_b) == '0) |-> !irq_pull);

endmodule

// File: tb/test_dual_host_regs.sv
module test_dual_host_regs;
    import dhr_pkg::*;

    localparam int H = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [DW-1:0]   pb_ad_i = '0;
    logic [DW-1:0]   pb_ad_o;
    logic            pb_ad_oe;
    logic            pb_ale = 1'b0;
    logic            pb_wr_n = 1'b1;
    logic            pb_rd_n = 1'b1;
    logic            pb_cs = 1'b0;
    logic            scl = 1'b1;
    logic            m_sda = 1'b1;
    logic            bus_sda;
    logic            i2c_sda_oe;
    logic [BUSW-1:0] stat_v;
    logic [BUSW-1:0] ctrl_o;
    logic            irq_pull;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    string         tag_q[$];
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] act_q[$];

    always #5 clk = ~clk;

    assign bus_sda = m_sda & ~i2c_sda_oe;

    dual_host_regs i_dual_host_regs (
        .clk        (clk),
        .rst        (rst),
        .pb_ad_i    (pb_ad_i),
        .pb_ad_o    (pb_ad_o),
        .pb_ad_oe   (pb_ad_oe),
        .pb_ale     (pb_ale),
        .pb_wr_n    (pb_wr_n),
        .pb_rd_n    (pb_rd_n),
        .pb_cs      (pb_cs),
        .i2c_scl_i  (scl),
        .i2c_sda_i  (bus_sda),
        .i2c_sda_oe (i2c_sda_oe),
        .stat_i     (stat_v),
        .ctrl_o     (ctrl_o),
        .irq_pull   (irq_pull)
    );

    function automatic logic [DW-1:0] cbyte(input int i);
        return ctrl_o[i*DW +: DW];
    endfunction

    // Driver side of the scoreboard
    task automatic sb(input string tag, input logic [DW-1:0] e, input logic [DW-1:0] a);
        tag_q.push_back(tag);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    // Monitor: pops and compares
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                string t;
                logic [DW-1:0] e, a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = act_q.pop_front();
                nchk++;
                if (a !== e) begin
                    nerr++;
                    $display("FAIL %s: actual=0x%02h expected=0x%02h", t, a, e);
                end
            end
        end
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic pb_addr_phase(input logic [DW-1:0] a);
        @(negedge clk);
        pb_ad_i = a;
        pb_ale  = 1'b1;
        repeat (4) @(negedge clk);
        pb_ale  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pb_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input logic cs);
        pb_addr_phase(a);
        pb_ad_i = d;
        repeat (2) @(negedge clk);
        pb_cs   = cs;
        pb_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        pb_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        pb_cs   = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pb_read(input logic [DW-1:0] a, input logic cs,
                           output logic [DW-1:0] d, output logic oe);
        pb_addr_phase(a);
        pb_cs   = cs;
        pb_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        d  = pb_ad_o;
        oe = pb_ad_oe;
        pb_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        pb_cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; scl = 1'b1; hw();
        m_sda = 1'b0; hw();
        scl = 1'b0; hw();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; hw();
        scl = 1'b1; hw();
        m_sda = 1'b1; hw();
    endtask

    // Sends one byte, returns the ninth-bit level; optionally collides
    // the last SCL fall with a parallel write strobe
    task automatic i2c_tx(input logic [7:0] b, output logic nack,
                          input bit collide, input logic [7:0] pd, input logic [7:0] sd,
                          input int loc);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            hw();
            scl = 1'b1;
            hw();
            scl = 1'b0;
            if (collide && i == 0) begin
                pb_wr_n = 1'b0;
                repeat (4) @(posedge clk);
                @(negedge clk);
                sb("R11 parallel value first", pd, cbyte(loc));
                @(negedge clk);
                sb("R11 serial value next cycle", sd, cbyte(loc));
            end
            hw();
            if (collide && i == 0) begin
                pb_wr_n = 1'b1;
                repeat (2) @(negedge clk);
                pb_cs = 1'b0;
            end
        end
        m_sda = 1'b1;
        hw();
        scl = 1'b1;
        hw();
        nack = bus_sda;
        scl = 1'b0;
        hw();
    endtask

    task automatic i2c_rx(output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw();
            scl = 1'b1;
            hw();
            b[i] = bus_sda;
            scl = 1'b0;
        end
        hw();
        scl = 1'b1;
        hw();
        scl = 1'b0;
        hw();
    endtask

    task automatic i2c_wr(input logic [7:0] p, input logic [7:0] d, input string tag);
        logic nk;
        i2c_start();
        i2c_tx(8'h3E, nk, 0, 8'h00, 8'h00, 0);
        sb({tag, " addr ack"}, 8'h00, {7'h0, nk});
        i2c_tx(p, nk, 0, 8'h00, 8'h00, 0);
        sb({tag, " ptr ack"}, 8'h00, {7'h0, nk});
        i2c_tx(d, nk, 0, 8'h00, 8'h00, 0);
        sb({tag, " data ack"}, 8'h00, {7'h0, nk});
        i2c_stop();
    endtask

    task automatic i2c_rd(input logic [7:0] p, output logic [7:0] d);
        logic nk;
        i2c_start();
        i2c_tx(8'h3E, nk, 0, 8'h00, 8'h00, 0);
        i2c_tx(p, nk, 0, 8'h00, 8'h00, 0);
        i2c_stop();
        i2c_start();
        i2c_tx(8'h3F, nk, 0, 8'h00, 8'h00, 0);
        sb("R5 read address ack", 8'h00, {7'h0, nk});
        i2c_rx(d);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe, nk;
        logic       any;

        for (int i = 0; i < NREG; i++) stat_v[i*DW +: DW] = 8'hC0 ^ 8'(i);
        stat_v[12*DW +: DW] = 8'h04;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1, R13: reset state
        any = 1'b0;
        for (int i = 0; i < NREG; i++) any |= (cbyte(i) != 8'h00);
        sb("R1 control bank zero after reset", 8'h00, {7'h0, any});
        sb("R13 pb_ad_oe after reset", 8'h00, {7'h0, pb_ad_oe});
        sb("R13 i2c_sda_oe after reset", 8'h00, {7'h0, i2c_sda_oe});
        sb("R13 irq_pull after reset", 8'h00, {7'h0, irq_pull});

        // R2: parallel writes
        pb_write(8'h03, 8'hA5, 1'b1);
        sb("R2 parallel write loc 3", 8'hA5, cbyte(3));
        pb_write(8'h07, 8'h3C, 1'b1);
        sb("R2 parallel write loc 7", 8'h3C, cbyte(7));

        // R3, R8: parallel read returns status, not control
        pb_read(8'h03, 1'b1, d, oe);
        sb("R3 R8 parallel read loc 3 status", 8'hC3, d);
        sb("R3 output enable during read", 8'h01, {7'h0, oe});
        sb("R3 output enable released", 8'h00, {7'h0, pb_ad_oe});

        // R4: chip select low
        pb_write(8'h03, 8'hFF, 1'b0);
        sb("R4 write with cs low ignored", 8'hA5, cbyte(3));
        pb_read(8'h03, 1'b0, d, oe);
        sb("R4 no drive with cs low", 8'h00, {7'h0, oe});

        // R6, R5: I2C write with acks
        i2c_wr(8'h09, 8'h77, "R5 R6");
        sb("R6 I2C write loc 9", 8'h77, cbyte(9));

        // R9: low 5 bits only
        i2c_wr(8'h25, 8'h11, "R9");
        sb("R9 I2C pointer 0x25 hits loc 5", 8'h11, cbyte(5));
        pb_write(8'hE2, 8'h6B, 1'b1);
        sb("R9 parallel addr 0xE2 hits loc 2", 8'h6B, cbyte(2));

        // R7, R8: I2C read through persistent pointer
        i2c_rd(8'h04, d);
        sb("R7 I2C read status loc 4", 8'hC4, d);
        sb("R8 read did not touch control loc 4", 8'h00, cbyte(4));
        i2c_rd(8'h07, d);
        sb("R8 I2C read loc 7 gives status", 8'hC7, d);

        // R5: foreign slave address
        i2c_start();
        i2c_tx(8'h40, nk, 0, 8'h00, 8'h00, 0);
        sb("R5 foreign address nack", 8'h01, {7'h0, nk});
        i2c_tx(8'h0A, nk, 0, 8'h00, 8'h00, 0);
        sb("R5 byte after foreign address nack", 8'h01, {7'h0, nk});
        i2c_tx(8'h99, nk, 0, 8'h00, 8'h00, 0);
        i2c_stop();
        sb("R5 foreign transaction writes nothing", 8'h00, cbyte(10));

        // R10: reserved locations
        pb_write(8'h1D, 8'h55, 1'b1);
        sb("R10 reserved parallel write ignored", 8'h00, cbyte(29));
        i2c_wr(8'h1E, 8'h66, "R10");
        sb("R10 reserved I2C write ignored", 8'h00, cbyte(30));
        pb_read(8'h1D, 1'b1, d, oe);
        sb("R10 reserved parallel read zero", 8'h00, d);
        i2c_rd(8'h1D, d);
        sb("R10 reserved I2C read zero", 8'h00, d);

        // R11: simultaneous writes to loc 6
        i2c_start();
        i2c_tx(8'h3E, nk, 0, 8'h00, 8'h00, 0);
        i2c_tx(8'h06, nk, 0, 8'h00, 8'h00, 0);
        pb_addr_phase(8'h06);
        pb_ad_i = 8'h12;
        pb_cs   = 1'b1;
        i2c_tx(8'h34, nk, 1, 8'h12, 8'h34, 6);
        i2c_stop();
        sb("R11 serial value remains", 8'h34, cbyte(6));

        // R12: interrupt
        sb("R12 irq idle with mask zero", 8'h00, {7'h0, irq_pull});
        pb_write(8'h0B, 8'h04, 1'b1);
        sb("R12 irq on overlapping mask", 8'h01, {7'h0, irq_pull});
        pb_write(8'h0B, 8'h08, 1'b1);
        sb("R12 irq off on disjoint mask", 8'h00, {7'h0, irq_pull});
        @(negedge clk);
        stat_v[12*DW +: DW] = 8'h0C;
        repeat (2) @(negedge clk);
        sb("R12 irq follows status bit", 8'h01, {7'h0, irq_pull});

        wait (act_q.size() == 0);
        #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule